// File: doc/BRIEF.md
# Start Word Detector with Bit Clock Recovery

This block watches a sliced, asynchronous serial receive line for a fixed 16-bit start word. Until that word appears, the data output simply mirrors the incoming line and the clock output stays low. Once the word is seen, the block takes over the data output. It then produces one clock pulse per bit and presents each following bit on the data output, so a host can shift in a packet without doing its own bit timing.

Bit timing comes from an oversampling counter. It runs at sixteen ticks per bit at the selected rate, and every line transition re-centres it, so each bit is sampled in the middle of its cell. Clocking, once started, runs until the host clears the enable. The host then sets the enable again to hunt for the next packet.

Top module: `start_sync_rx`

## Requirements
- R1: While `en` is high, every mid-bit sample is shifted into a 16-bit history, oldest bit in the most significant position. Detection occurs when that history equals `START_WORD` (default 16'hE2E2, sent most significant bit first). A pattern differing in any bit (for example 16'hE2E3) produces no detection.
- R2: `rx_clk` is low during reset, whenever `en` is low, and while enabled before a start word has been detected.
- R3: Let a bit of the line begin when `din` changes just after a falling clock edge. For each bit after the start word, `rx_clk` rises at the 3+8*D-th rising clock edge counted from the start of that bit. Here D is the tick divisor of R7. The first rise therefore lands mid-bit of the first post-start bit, and later rises follow every 16*D clocks.
- R4: The recovered bit appears on `rx_data` in the same cycle that `rx_clk` rises. It does not change while `rx_clk` is high. `rx_clk` stays high for exactly 8*D clocks.
- R5: While `en` is low, and while enabled before detection, `rx_data` equals `din` combinationally. From detection onward it carries the recovered bit.
- R6: After detection, clocking continues for any data, with no further start word, until `en` is cleared. After `en` is set again, no clock appears until a fresh start word is received.
- R7: `rate_sel` codes 0 to 8 select 1200, 2400, 4800, 9600, 19200, 38400, 57600, 115200 and 230400 b/s. The tick divisor is D = CLK_HZ/(16*rate), rounded to nearest.
- R8: `rate_sel` codes 9 to 15 behave exactly as code 0 (1200 b/s).
- R9: `din` passes through a two-stage synchronizer. Every transition on it restarts the tick and phase counters, so bit timing follows the transmitter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 1 | Asynchronous sliced receive data |
| en | input | 1 | Enables start-word hunting; clearing it stops clocking |
| rate_sel | input | 4 | Bit rate code |
| rx_data | output | 1 | Raw line before detection, recovered bit after |
| rx_clk | output | 1 | Recovered bit clock, rising mid-bit |

## Verification
The assertions assume that `rate_sel` is held steady while `en` is high. They also assume that transitions on `din` are spaced close to whole bit periods, so the phase counter reaches its centre value between edges. The stimulus changes the rate only while the block is disabled. It drives bits of exactly 16*D clocks, which places the exact timing checks of R3 and R4 on a known cycle grid. Runs of all-ones and all-zeros payloads exercise stretches with no realigning edge.

// File: rtl/start_sync_rx.sv
module start_sync_rx #(
  parameter int unsigned CLK_HZ     = 250_000_000,
  parameter logic [15:0] START_WORD = 16'hE2E2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       din,
  input  logic       en,
  input  logic [3:0] rate_sel,
  output logic       rx_data,
  output logic       rx_clk
);

  localparam longint unsigned DIV_MAX = (longint'(CLK_HZ) + 9600) / 19200;
  localparam int CW = $clog2(DIV_MAX + 1);

  function automatic logic [CW-1:0] div_of(input logic [3:0] code);
    longint unsigned r, d;
    case (code)
      4'd1:    r = 2400;
      4'd2:    r = 4800;
      4'd3:    r = 9600;
      4'd4:    r = 19200;
      4'd5:    r = 38400;
      4'd6:    r = 57600;
      4'd7:    r = 115200;
      4'd8:    r = 230400;
      default: r = 1200;
    endcase
    d = (longint'(CLK_HZ) + 8 * r) / (16 * r);
    if (d == 0) d = 1;
    return CW'(d);
  endfunction

  logic [CW-1:0] div_now, tcnt;
  logic [3:0]    phase;
  logic [15:0]   hist;
  logic          s1, s2, s3, locked, rdata, rclk;
  logic          edge_w, tick, samp;

  assign div_now = div_of(rate_sel);
  assign edge_w  = s2 ^ s3;
  assign tick    = (tcnt >= div_now - CW'(1));
  assign samp    = tick && !edge_w && (phase == 4'd7);
  assign rx_data = locked ? rdata : din;
  assign rx_clk  = rclk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
      tcnt <= '0; phase <= '0; hist <= '0;
      locked <= 1'b0; rdata <= 1'b0; rclk <= 1'b0;
    end else begin
      s1 <= din; s2 <= s1; s3 <= s2;
      tcnt <= (edge_w || tick) ? '0 : tcnt + CW'(1);
      if (edge_w)    phase <= '0;
      else if (tick) phase <= phase + 4'd1;
      if (!en) begin
        hist <= '0; locked <= 1'b0; rclk <= 1'b0;
      end else if (samp) begin
        hist <= {hist[14:0], s2};
        if (locked) begin
          rdata <= s2;
          rclk  <= 1'b1;
        end else if ({hist[14:0], s2} == START_WORD) begin
          locked <= 1'b1;
          rdata  <= s2;
        end
      end else if (rclk && (edge_w || (tick && phase == 4'd15))) begin
        rclk <= 1'b0;
      end
    end
  end

  assert_clk_low_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !rx_clk);
  assert_rise_midbit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_clk) |-> (phase == 4'd8));
  assert_data_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_clk && $past(rx_clk)) |-> $stable(rx_data));
  assert_lock_needs_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(en));
  assert_tick_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(rate_sel) && $past(tcnt) < $past(div_now)) |-> (tcnt < div_now));

endmodule

// File: tb/start_sync_rx_tb.sv
module start_sync_rx_tb;
  localparam int unsigned CLK_HZ = 3_686_400;
  localparam logic [11:0] VEC [0:5] = '{12'h8A5, 12'h73C, 12'h6FF, 12'h500, 12'h4C3, 12'hC96};

  logic clk = 1'b0, rst_n = 1'b0, din = 1'b1, en = 1'b0;
  logic [3:0] rate_sel = 4'd8;
  logic rx_data, rx_clk;

  start_sync_rx #(.CLK_HZ(CLK_HZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .din(din), .en(en),
    .rate_sel(rate_sel), .rx_data(rx_data), .rx_clk(rx_clk));

  always #2 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0;
  int unsigned ncyc = 0;
  int nr = 0;
  int unsigned rise_t [256];
  logic rise_d [256];
  int unsigned hi_len [256];
  logic unstable [256];
  logic prev_c = 1'b0, held = 1'b0;

  always @(negedge clk) begin
    ncyc++;
    if (rx_clk && !prev_c) begin
      if (nr < 256) begin rise_t[nr] = ncyc; rise_d[nr] = rx_data; unstable[nr] = 1'b0; end
      held = rx_data;
    end else if (rx_clk && prev_c && rx_data != held && nr < 256) unstable[nr] = 1'b1;
    if (!rx_clk && prev_c) begin
      if (nr < 256) hi_len[nr] = ncyc - rise_t[nr];
      nr++;
    end
    prev_c = rx_clk;
  end

  function automatic int exp_div(input logic [3:0] c);
    int r;
    case (c)
      4'd1: r = 2400;   4'd2: r = 4800;   4'd3: r = 9600;
      4'd4: r = 19200;  4'd5: r = 38400;  4'd6: r = 57600;
      4'd7: r = 115200; 4'd8: r = 230400;
      default: r = 1200;
    endcase
    return CLK_HZ / (16 * r);
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input int d);
    din = b;
    repeat (16 * d) @(negedge clk);
    #1;
  endtask

  task automatic send_bits(input logic [15:0] v, input int n, input int d);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i], d);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 190000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", ncyc, 0);
    finish_run();
  end

  initial begin
    int base, d, p0;
    logic [3:0] code;
    logic [7:0] pay;

    repeat (3) @(negedge clk);
    din = 1'b0; #1;
    check(rx_clk == 1'b0, "R2 reset clk low", rx_clk, 0);
    check(rx_data == 1'b0, "R5 reset raw pass 0", rx_data, 0);
    din = 1'b1; #1;
    check(rx_data == 1'b1, "R5 reset raw pass 1", rx_data, 1);
    rst_n = 1'b1;
    @(negedge clk); #1;

    // disabled: start word ignored, raw data passes
    rate_sel = 4'd8; d = exp_div(4'd8); base = nr;
    send_bits(16'h0001, 2, d);
    send_bits(16'hE2E2, 16, d);
    din = 1'b0; #1;
    check(rx_data == 1'b0, "R5 disabled raw pass", rx_data, 0);
    send_bits(16'h00A5, 8, d);
    check(nr == base, "R2 no clock while disabled", nr - base, 0);

    // near miss word while enabled
    en = 1'b1; base = nr;
    send_bits(16'h0001, 2, d);
    send_bits(16'hE2E3, 16, d);
    send_bits(16'h0033, 8, d);
    check(nr == base, "R1 near-miss word no detect", nr - base, 0);
    check(rx_data == din, "R5 raw before detect", rx_data, din);
    en = 1'b0;

    for (int v = 0; v < 6; v++) begin
      code = VEC[v][11:8]; pay = VEC[v][7:0]; d = exp_div(code);
      rate_sel = code; din = 1'b1;
      repeat (20) @(negedge clk); #1;
      en = 1'b1; base = nr;
      send_bits(16'h0001, 2, d);
      send_bits(16'hE2E2, 16, d);
      p0 = ncyc;
      send_bits({8'h00, pay}, 8, d);
      send_bit(1'b1, d);
      check(nr - base >= 8, "R1 pulses after start word", nr - base, 8);
      for (int k = 0; k < 8; k++) begin
        check(rise_t[base+k] == p0 + 3 + 8*d + 16*d*k, "R3 R7 R8 rise time",
              rise_t[base+k], p0 + 3 + 8*d + 16*d*k);
        check(rise_d[base+k] == pay[7-k], "R4 recovered bit", rise_d[base+k], pay[7-k]);
        check(hi_len[base+k] == 8*d, "R4 high width", hi_len[base+k], 8*d);
        check(unstable[base+k] == 1'b0, "R4 stable while high", unstable[base+k], 0);
      end
      en = 1'b0;
    end

    // latch and re-arm
    rate_sel = 4'd7; d = exp_div(4'd7);
    repeat (20) @(negedge clk); #1;
    en = 1'b1;
    send_bits(16'h0001, 2, d);
    send_bits(16'hE2E2, 16, d);
    base = nr;
    send_bits(16'hFFFF, 16, d);
    send_bits(16'h0F0F, 16, d);
    check(nr - base >= 31, "R6 clocking stays on", nr - base, 31);
    en = 1'b0;
    @(negedge clk); #1;
    @(negedge clk); #1;
    check(rx_clk == 1'b0, "R6 clock stops on clear", rx_clk, 0);
    din = ~din; #1;
    check(rx_data == din, "R5 raw after clear", rx_data, din);
    en = 1'b1; base = nr;
    send_bits(16'h5555, 16, d);
    send_bits(16'h00C3, 8, d);
    check(nr == base, "R6 no clock until new word", nr - base, 0);
    check(rx_clk == 1'b0, "R2 clock low before detect", rx_clk, 0);
    send_bits(16'hE2E2, 16, d);
    p0 = ncyc; base = nr;
    send_bits(16'h0001, 2, d);
    check(rise_t[base] == p0 + 3 + 8*d, "R6 R9 rearm rise time", rise_t[base], p0 + 3 + 8*d);
    check(rise_d[base] == 1'b0, "R6 rearm first bit", rise_d[base], 0);
    en = 1'b0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule